// File: doc/BRIEF.md
# Signed BCD Phase Step Counter

This block keeps a running count of how far a phase shifter has been moved away from its starting point. Each completed phase step is reported by a one-cycle done pulse and a direction bit. On each such pulse the count moves by one. The count is held as a sign bit and three BCD digits, so it can go straight to a decimal display or a monitor. It passes through zero in sign-magnitude form and stops at plus or minus 255.

Once the automatic alignment has finished, two push inputs let an operator ask for one extra step up or down. Each rising edge of a push input sends out one step request pulse with its direction. The block then waits for the phase shifter to report the step done. A push that would take the count past the limit sends out no request. The count register gives a valid value at every cycle, including during training.

All pins are plain control and status pins. No data stream crosses this block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `phase_bcd_tracker`

## Requirements
- R1: After reset, `phase_bcd` is all zero (positive zero) and `step_req` is low.
- R2: A cycle with `step_done`=1 and `step_up`=1 moves the count up by one in the cycle after. The count is coded as bit 12 = sign (1 = negative), bits 11:8 hundreds, bits 7:4 tens, bits 3:0 units. Each digit goes from 9 to 0 and carries into the next digit, and no digit ever goes above 9.
- R3: A cycle with `step_done`=1 and `step_up`=0 moves the count down by one in the cycle after. A digit goes from 0 to 9 and borrows from the next digit.
- R4: In a cycle without `step_done`, the count does not change.
- R5: Stepping up from −1 gives +0 with the sign clear. Stepping down from +0 gives −1 with the sign set. The sign is never set while the magnitude is zero.
- R6: A done pulse that would take the count above +255 or below −255 leaves the count unchanged.
- R7: While `train_done` is low, presses on `man_up` and `man_dn` produce no step request.
- R8: A rising edge on `man_up` (or `man_dn`) produces exactly one `step_req` pulse, one cycle long, in the following cycle. `step_req_up` is 1 for up and 0 for down. Holding the input high produces no further pulse.
- R9: A manual press up at +255, or down at −255, produces no step request.
- R10: After a manual request, further presses are ignored until a `step_done` arrives. A cycle in which both push inputs rise together is also ignored.
- R11: `step_done` pulses change the count whether or not `train_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_done | input | 1 | High once automatic alignment has finished; enables the push inputs |
| step_done | input | 1 | One-cycle pulse: a phase step has completed |
| step_up | input | 1 | Direction of the completed step (1 = up) |
| man_up | input | 1 | Operator push input, step up |
| man_dn | input | 1 | Operator push input, step down |
| step_req | output | 1 | One-cycle pulse asking the phase shifter for one step |
| step_req_up | output | 1 | Direction of the request (1 = up), valid while `step_req` is high |
| phase_bcd | output | 13 | Signed BCD count: sign in bit 12, three digits below it |

## Verification
Both results are one register away from their cause. A done pulse seen at a clock edge shows up in `phase_bcd` right after that edge. A push input that is high at an edge, after being low at the edge before, raises `step_req` right after that edge, for one cycle. The bench drives inputs and samples outputs on the falling edge. It moves its integer reference model on the same rising edge as the design. The two are then compared at the next falling edge, so each comparison sees exactly one register stage.

// File: rtl/phase_bcd_pkg.sv
package phase_bcd_pkg;
  localparam int DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] bcd_digit_t;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } step_dir_e;
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import phase_bcd_pkg::*;
(
  input  bcd_digit_t digit_i,
  input  logic       en_i,
  input  logic       up_i,
  output bcd_digit_t digit_o,
  output logic       carry_o
);
  always_comb begin
    digit_o = digit_i;
    carry_o = 1'b0;
    if (en_i) begin
      if (up_i) begin
        if (digit_i >= bcd_digit_t'(9)) begin
          digit_o = '0;
          carry_o = 1'b1;
        end else begin
          digit_o = digit_i + bcd_digit_t'(1);
        end
      end else begin
        if (digit_i == '0) begin
          digit_o = bcd_digit_t'(9);
          carry_o = 1'b1;
        end else begin
          digit_o = digit_i - bcd_digit_t'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bcd_mag_reg.sv
module bcd_mag_reg
  import phase_bcd_pkg::*;
#(
  parameter int NDIG      = 3,
  parameter int MAG_LIMIT = 255,
  localparam int MAG_W    = NDIG * DIGIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic             grow_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             zero_o,
  output logic             one_o,
  output logic             full_o
);
  logic [MAG_W-1:0] mag_q, mag_d;
  logic [NDIG:0]    chain;
  logic [NDIG-1:0]  dig_zero, dig_full;

  assign chain[0] = upd_i;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    localparam int LIM_DIG = (MAG_LIMIT / (10 ** i)) % 10;

    bcd_digit_cell u_cell (
      .digit_i (mag_q[i*DIGIT_W +: DIGIT_W]),
      .en_i    (chain[i]),
      .up_i    (grow_i),
      .digit_o (mag_d[i*DIGIT_W +: DIGIT_W]),
      .carry_o (chain[i+1])
    );

    assign dig_zero[i] = (mag_q[i*DIGIT_W +: DIGIT_W] == '0);
    assign dig_full[i] = (mag_q[i*DIGIT_W +: DIGIT_W] == bcd_digit_t'(LIM_DIG));

    a_r2_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
      mag_q[i*DIGIT_W +: DIGIT_W] <= bcd_digit_t'(9));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mag_q <= '0;
    else        mag_q <= mag_d;
  end

  assign mag_o  = mag_q;
  assign zero_o = &dig_zero;
  assign full_o = &dig_full;
  if (NDIG > 1) begin : g_one_multi
    assign one_o = (mag_q[DIGIT_W-1:0] == bcd_digit_t'(1)) && (&dig_zero[NDIG-1:1]);
  end else begin : g_one_single
    assign one_o = (mag_q[DIGIT_W-1:0] == bcd_digit_t'(1));
  end
endmodule

// File: rtl/manual_req_gen.sv
module manual_req_gen
  import phase_bcd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic train_i,
  input  logic up_i,
  input  logic dn_i,
  input  logic done_i,
  input  logic at_max_i,
  input  logic at_min_i,
  output logic req_o,
  output logic dir_o
);
  logic      up_prev_q, dn_prev_q, pend_q, req_q;
  step_dir_e dir_q;
  logic      up_edge, dn_edge, fire_up, fire_dn, fire;

  assign up_edge = up_i & ~up_prev_q;
  assign dn_edge = dn_i & ~dn_prev_q;
  assign fire_up = train_i & ~pend_q & up_edge & ~dn_edge & ~at_max_i;
  assign fire_dn = train_i & ~pend_q & dn_edge & ~up_edge & ~at_min_i;
  assign fire    = fire_up | fire_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_prev_q <= 1'b0;
      dn_prev_q <= 1'b0;
      pend_q    <= 1'b0;
      req_q     <= 1'b0;
      dir_q     <= DIR_DOWN;
    end else begin
      up_prev_q <= up_i;
      dn_prev_q <= dn_i;
      pend_q    <= (pend_q & ~done_i) | fire;
      req_q     <= fire;
      if (fire) dir_q <= fire_up ? DIR_UP : DIR_DOWN;
    end
  end

  assign req_o = req_q;
  assign dir_o = dir_q;

  a_r7_req_needs_train: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(train_i));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  a_r10_no_req_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !done_i) |=> !req_q);
endmodule

// File: rtl/phase_bcd_tracker.sv
module phase_bcd_tracker
  import phase_bcd_pkg::*;
#(
  parameter int NDIG      = 3,
  parameter int MAG_LIMIT = 255,
  localparam int MAG_W    = NDIG * DIGIT_W,
  localparam int PHASE_W  = MAG_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               train_done,
  input  logic               step_done,
  input  logic               step_up,
  input  logic               man_up,
  input  logic               man_dn,
  output logic               step_req,
  output logic               step_req_up,
  output logic [PHASE_W-1:0] phase_bcd
);
  logic             neg_q, neg_d;
  logic [MAG_W-1:0] mag;
  logic             zero, one, full;
  logic             grow, upd;

  // Moving away from zero grows the magnitude; from zero both directions grow.
  assign grow = step_up ? ~neg_q : (neg_q | zero);
  assign upd  = step_done & ~(grow & full);

  always_comb begin
    neg_d = neg_q;
    if (upd) begin
      if (grow) neg_d = zero ? ~step_up : neg_q;
      else      neg_d = one ? 1'b0 : neg_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= neg_d;
  end

  bcd_mag_reg #(.NDIG(NDIG), .MAG_LIMIT(MAG_LIMIT)) u_mag (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_i  (upd),
    .grow_i (grow),
    .mag_o  (mag),
    .zero_o (zero),
    .one_o  (one),
    .full_o (full)
  );

  manual_req_gen u_man (
    .clk      (clk),
    .rst_n    (rst_n),
    .train_i  (train_done),
    .up_i     (man_up),
    .dn_i     (man_dn),
    .done_i   (step_done),
    .at_max_i (full & ~neg_q),
    .at_min_i (full & neg_q),
    .req_o    (step_req),
    .dir_o    (step_req_up)
  );

  assign phase_bcd = {neg_q, mag};

  a_r5_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    phase_bcd[PHASE_W-1] |-> (|phase_bcd[MAG_W-1:0]));
  a_r4_hold_without_done: assert property (@(posedge clk) disable iff (!rst_n)
    !step_done |=> $stable(phase_bcd));
  a_r6_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && step_up && !phase_bcd[PHASE_W-1] && full) |=> $stable(phase_bcd));
  a_r6_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && !step_up && phase_bcd[PHASE_W-1] && full) |=> $stable(phase_bcd));
endmodule

// File: tb/tb_phase_bcd_tracker.sv
`timescale 1ns/1ps
module tb_phase_bcd_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        train_done = 1'b0;
  logic        step_done = 1'b0;
  logic        step_up = 1'b0;
  logic        man_up = 1'b0;
  logic        man_dn = 1'b0;
  logic        step_req;
  logic        step_req_up;
  logic [12:0] phase_bcd;

  int    vectors = 0;
  int    fails = 0;
  bit    finished = 0;
  string tag = "R1";

  int e_cnt = 0;
  bit e_req = 0, e_dir = 0, p_up = 0, p_dn = 0, pend = 0;

  always #4 clk = ~clk;

  phase_bcd_tracker dut (
    .clk(clk), .rst_n(rst_n), .train_done(train_done), .step_done(step_done),
    .step_up(step_up), .man_up(man_up), .man_dn(man_dn),
    .step_req(step_req), .step_req_up(step_req_up), .phase_bcd(phase_bcd)
  );

  function automatic logic [12:0] to_bcd(int v);
    int m;
    m = (v < 0) ? -v : v;
    return {v < 0, 4'((m / 100) % 10), 4'((m / 10) % 10), 4'(m % 10)};
  endfunction

  // Behavioural reference: integer count plus request bookkeeping.
  always @(posedge clk) begin
    bit ue, de, fire;
    if (!rst_n) begin
      e_cnt = 0; e_req = 0; e_dir = 0; p_up = 0; p_dn = 0; pend = 0;
    end else begin
      ue = man_up && !p_up;
      de = man_dn && !p_dn;
      fire = 0;
      if (train_done && !pend && (ue != de)) begin
        if (ue && e_cnt < 255) begin fire = 1; e_dir = 1; end
        if (de && e_cnt > -255) begin fire = 1; e_dir = 0; end
      end
      pend = (pend && !step_done) || fire;
      e_req = fire;
      p_up = man_up;
      p_dn = man_dn;
      if (step_done) begin
        if (step_up && e_cnt < 255) e_cnt = e_cnt + 1;
        else if (!step_up && e_cnt > -255) e_cnt = e_cnt - 1;
      end
    end
  end

  task automatic check();
    logic [12:0] exp_p;
    exp_p = to_bcd(e_cnt);
    vectors++;
    if (phase_bcd !== exp_p) begin
      fails++;
      $display("FAIL %s phase_bcd got %h expected %h", tag, phase_bcd, exp_p);
    end
    vectors++;
    if (step_req !== e_req) begin
      fails++;
      $display("FAIL %s step_req got %b expected %b", tag, step_req, e_req);
    end
    if (e_req) begin
      vectors++;
      if (step_req_up !== e_dir) begin
        fails++;
        $display("FAIL %s step_req_up got %b expected %b", tag, step_req_up, e_dir);
      end
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check();
  endtask

  task automatic step(bit up);
    step_done = 1'b1; step_up = up;
    cyc();
    step_done = 1'b0;
    cyc();
  endtask

  task automatic press(bit up, int hold);
    if (up) man_up = 1'b1; else man_dn = 1'b1;
    for (int k = 0; k < hold; k++) cyc();
    man_up = 1'b0; man_dn = 1'b0;
    cyc();
  endtask

  initial begin
    tag = "R1";
    for (int k = 0; k < 4; k++) cyc();
    rst_n = 1'b1;
    cyc();
    // R2 and R11: count up through the units carry while training is still running
    tag = "R2";
    for (int k = 0; k < 12; k++) step(1);
    tag = "R4";
    for (int k = 0; k < 6; k++) cyc();
    // R3: count down through the borrow at 10 -> 9
    tag = "R3";
    for (int k = 0; k < 4; k++) step(0);
    // R5: cross zero downward, then back up
    tag = "R5";
    for (int k = 0; k < 11; k++) step(0);
    for (int k = 0; k < 4; k++) step(1);
    // R7: pushes ignored before training is done
    tag = "R7";
    press(1, 3);
    press(0, 2);
    // R11 and R6: go to +255, then try to go past it
    tag = "R6";
    for (int k = 0; k < 260; k++) step(1);
    train_done = 1'b1;
    cyc();
    // R9: push up at the upper limit
    tag = "R9";
    press(1, 2);
    // R8: held push down gives one pulse, then the step completes
    tag = "R8";
    press(0, 5);
    step(0);
    press(1, 1);
    step(1);
    // R10: pushes while pending are ignored; a simultaneous rise is ignored
    tag = "R10";
    press(0, 1);
    press(1, 1);
    press(0, 1);
    step(0);
    man_up = 1'b1; man_dn = 1'b1;
    cyc();
    man_up = 1'b0; man_dn = 1'b0;
    cyc();
    // R6 and R9 at the lower limit
    tag = "R6";
    for (int k = 0; k < 515; k++) step(0);
    tag = "R9";
    press(0, 2);
    press(1, 1);
    step(1);
    tag = "R5";
    for (int k = 0; k < 4; k++) cyc();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired at tag %s", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule